// File: doc/BRIEF.md
# Link Port Word Transmitter

This block is the transmit half of a narrow parallel link. A producer hands it 32-bit or 48-bit words through a valid/ready stream. The block keeps one word in a holding stage and a second in a shift register, and sends the word in the shift register over an 8-bit lane bus, one beat per clock. In single-rate mode each beat carries a 4-bit nibble. In double-rate mode each beat carries a full byte, which halves the number of beats per word.

Word width and rate are plain control inputs, sampled together with each word as it is accepted. Both settings therefore travel with the word, and the beat counter reloads from them when that word reaches the shift register. The holding stage empties as soon as its word moves into the shift register, so `in_ready` rises again while the current word is still going out. A producer that answers in time keeps the link busy with no idle beat. If no word is waiting when the last beat of a word leaves, the block reports an underrun.

Back-pressure rules: a word is transferred on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on internal state, never on `in_valid`. While `in_ready` is low the producer holds its word, width and rate stable.

Top module: `lp_word_tx`

## Requirements
- R1: After reset `lnk_valid` is 0, `lnk_data` is 0, `underrun` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when the holding stage is empty. A transfer fills the holding stage, so `in_ready` is 0 in the next cycle. An offered word is not taken while `in_ready` is 0.
- R3: In single-rate mode (`cfg_dbl`=0) each beat puts 4 bits on `lnk_data[3:0]`, least significant nibble first, and `lnk_data[7:4]` is 0.
- R4: In double-rate mode (`cfg_dbl`=1) each beat puts 8 bits on `lnk_data[7:0]`, least significant byte first.
- R5: A word takes 8 beats when 32-bit and single-rate, 12 beats when 48-bit (`cfg_wide`=1) and single-rate, 4 beats when 32-bit and double-rate, and 6 beats when 48-bit and double-rate.
- R6: Width and rate are captured with the word at transfer. Changing `cfg_wide` or `cfg_dbl` afterwards does not alter the beats of that word.
- R7: `in_ready` rises in the same cycle that the first beat of the held word appears, one cycle after the word moved into the shift register.
- R8: When a word is transferred into an idle, empty block, its first beat appears in the second cycle after the transfer edge.
- R9: If the next word is already held when the last beat of the current word leaves, the first beat of the next word follows in the very next cycle, with no idle beat.
- R10: When no beat is being sent, `lnk_valid` is 0 and `lnk_data` is 0.
- R11: `underrun` is high for exactly one cycle, the cycle after a last beat that left while the holding stage was empty.
- R12: For a 32-bit word, `in_data[47:32]` has no effect on any beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; one beat per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 selects a 48-bit word, 0 a 32-bit word; sampled at transfer |
| cfg_dbl | input | 1 | 1 selects byte beats, 0 nibble beats; sampled at transfer |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Holding stage empty; a word can be taken |
| in_data | input | 48 | Word to send; bits 47:32 are used only for 48-bit words |
| lnk_valid | output | 1 | A beat is on the lane bus |
| lnk_data | output | 8 | Beat payload |
| underrun | output | 1 | One-cycle pulse after a word ended with nothing waiting |

## Verification
The hardest condition to reach is the boundary between a gapless stream and an underrun. It depends on whether the next word reaches the holding stage before the last beat of the current word leaves. For short double-rate 32-bit words, that window is only a few cycles wide. The stimulus keeps `in_valid` high over several words so the producer answers on the first cycle `in_ready` returns, and it measures the contiguous run of beats. It then inserts random idle gaps between words of mixed width and rate, so that some words arrive just in time and some just too late.

// File: rtl/lp_pkg.sv
package lp_pkg;

  // Number of beats needed for a word, given its width and the lane size.
  function automatic int unsigned beats_for(input logic wide, input logic dbl,
                                            input int unsigned narrow_w,
                                            input int unsigned wide_w,
                                            input int unsigned lane_w);
    int unsigned bits;
    int unsigned per_beat;
    bits     = wide ? wide_w : narrow_w;
    per_beat = dbl ? 2 * lane_w : lane_w;
    return bits / per_beat;
  endfunction

endpackage

// File: rtl/lp_hold_stage.sv
module lp_hold_stage #(
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_wide,
  input  logic              push_dbl,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] held_data,
  output logic              held_wide,
  output logic              held_dbl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      held_data <= '0;
      held_wide <= 1'b0;
      held_dbl  <= 1'b0;
    end else begin
      if (push) begin
        full      <= 1'b1;
        held_data <= push_data;
        held_wide <= push_wide;
        held_dbl  <= push_dbl;
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lp_beat_ctr.sv
module lp_beat_ctr #(
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 48,
  parameter int LANE_W   = 4,
  parameter int CNT_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_wide,
  input  logic load_dbl,
  output logic busy,
  output logic ending
);
  import lp_pkg::*;

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] reload;

  always_comb begin
    reload = CNT_W'(beats_for(load_wide, load_dbl, NARROW_W, WIDE_W, LANE_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= reload;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy   = (left_q != '0);
  assign ending = (left_q <= CNT_W'(1));

endmodule

// File: rtl/lp_shifter.sv
module lp_shifter #(
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 48,
  parameter int LANE_W   = 4,
  parameter int LINK_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WIDE_W-1:0] load_data,
  input  logic              load_wide,
  input  logic              load_dbl,
  input  logic              busy,
  output logic              cur_dbl,
  output logic [LINK_W-1:0] lane_out
);

  localparam logic [WIDE_W-1:0] NARROW_MASK = WIDE_W'({NARROW_W{1'b1}});

  logic [WIDE_W-1:0] sh_q;
  logic              dbl_q;
  logic [WIDE_W-1:0] masked;

  always_comb begin
    masked = load_wide ? load_data : (load_data & NARROW_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      dbl_q <= 1'b0;
    end else if (load) begin
      sh_q  <= masked;
      dbl_q <= load_dbl;
    end else if (busy) begin
      sh_q <= dbl_q ? (sh_q >> LINK_W) : (sh_q >> LANE_W);
    end
  end

  always_comb begin
    lane_out = '0;
    if (busy) begin
      if (dbl_q) lane_out = sh_q[LINK_W-1:0];
      else       lane_out = LINK_W'(sh_q[LANE_W-1:0]);
    end
  end

  assign cur_dbl = dbl_q;

endmodule

// File: rtl/lp_word_tx.sv
module lp_word_tx #(
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 48,
  parameter int LANE_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wide,
  input  logic                cfg_dbl,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WIDE_W-1:0]   in_data,
  output logic                lnk_valid,
  output logic [2*LANE_W-1:0] lnk_data,
  output logic                underrun
);

  localparam int LINK_W    = 2 * LANE_W;
  localparam int MAX_BEATS = WIDE_W / LANE_W;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  logic              hold_full;
  logic [WIDE_W-1:0] hold_data;
  logic              hold_wide;
  logic              hold_dbl;
  logic              accept;
  logic              load;
  logic              beat_busy;
  logic              beat_ending;
  logic              beat_dbl;
  logic              underrun_q;

  assign in_ready = !hold_full;
  assign accept   = in_valid && !hold_full;
  // Move the held word in when the shift register is empty or on its last beat.
  assign load     = hold_full && beat_ending;

  lp_hold_stage #(.DATA_W(WIDE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (in_data),
    .push_wide (cfg_wide),
    .push_dbl  (cfg_dbl),
    .pop       (load),
    .full      (hold_full),
    .held_data (hold_data),
    .held_wide (hold_wide),
    .held_dbl  (hold_dbl)
  );

  lp_beat_ctr #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .LANE_W   (LANE_W),
    .CNT_W    (CNT_W)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_wide (hold_wide),
    .load_dbl  (hold_dbl),
    .busy      (beat_busy),
    .ending    (beat_ending)
  );

  lp_shifter #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .LANE_W   (LANE_W),
    .LINK_W   (LINK_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (hold_data),
    .load_wide (hold_wide),
    .load_dbl  (hold_dbl),
    .busy      (beat_busy),
    .cur_dbl   (beat_dbl),
    .lane_out  (lnk_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underrun_q <= 1'b0;
    else        underrun_q <= beat_busy && beat_ending && !hold_full;
  end

  assign lnk_valid = beat_busy;
  assign underrun  = underrun_q;

endmodule

// File: rtl/lp_word_tx_chk.sv
module lp_word_tx_chk #(
  parameter int LINK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              lnk_valid,
  input logic [LINK_W-1:0] lnk_data,
  input logic              underrun,
  input logic              beat_dbl
);

  p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_valid |-> lnk_data == '0);

  p_nibble_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_valid && !beat_dbl) |-> lnk_data[LINK_W-1:LINK_W/2] == '0);

  p_transfer_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_start_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lnk_valid) |-> (in_ready && $past(!in_ready)));

  p_underrun_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!lnk_valid && $past(lnk_valid)));

  p_underrun_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

endmodule

bind lp_word_tx lp_word_tx_chk #(.LINK_W(LINK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .lnk_valid (lnk_valid),
  .lnk_data  (lnk_data),
  .underrun  (underrun),
  .beat_dbl  (beat_dbl)
);

// File: tb/lp_word_tx_test.sv
module lp_word_tx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        cfg_dbl = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_data = '0;
  logic        lnk_valid;
  logic [7:0]  lnk_data;
  logic        underrun;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lp_word_tx uut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_dbl(cfg_dbl),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .lnk_valid(lnk_valid), .lnk_data(lnk_data), .underrun(underrun)
  );

  // Behavioural reference: pending words and a queue of expected beats.
  logic [47:0] pend_w[$];
  bit          pend_wide[$];
  bit          pend_dbl[$];
  int          beats[$];
  bit          beat_is_dbl[$];
  bit          exp_under = 0;

  task automatic expand(input logic [47:0] w, input bit wide, input bit dbl);
    int nbits = wide ? 48 : 32;
    int lane  = dbl ? 8 : 4;
    for (int i = 0; i < nbits / lane; i++) begin
      beats.push_back(int'((w >> (i * lane)) & ((48'd1 << lane) - 1)));
      beat_is_dbl.push_back(dbl);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pend_w.delete(); pend_wide.delete(); pend_dbl.delete();
      beats.delete(); beat_is_dbl.delete(); exp_under = 0;
    end else begin
      bit take;
      take = in_valid && (pend_w.size() == 0);
      exp_under = (beats.size() == 1) && (pend_w.size() == 0);
      if (beats.size() > 0) begin
        void'(beats.pop_front());
        void'(beat_is_dbl.pop_front());
      end
      if (beats.size() == 0 && pend_w.size() > 0) begin
        expand(pend_w.pop_front(), pend_wide.pop_front(), pend_dbl.pop_front());
      end
      if (take) begin
        pend_w.push_back(in_data);
        pend_wide.push_back(cfg_wide);
        pend_dbl.push_back(cfg_dbl);
      end
      cycles++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  int run_len = 0;
  int max_run = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ev;
      int ed;
      ev = (beats.size() > 0);
      ed = ev ? beats[0] : 0;
      // R5 R10: beat presence
      check(lnk_valid == ev, "R5 R10 lnk_valid", lnk_valid, ev);
      // R3 R4 R12: beat payload, lane order, unused upper bits ignored
      if (ev && !beat_is_dbl[0]) check(lnk_data == ed, "R3 R12 nibble beat", lnk_data, ed);
      else if (ev)               check(lnk_data == ed, "R4 R12 byte beat", lnk_data, ed);
      else                       check(lnk_data == 0, "R10 idle data", lnk_data, 0);
      // R2 R7: request to the holding stage
      check(in_ready == (pend_w.size() == 0), "R2 R7 in_ready", in_ready, pend_w.size() == 0);
      // R11: underrun pulse
      check(underrun == exp_under, "R11 underrun", underrun, exp_under);
      if (lnk_valid) begin
        run_len++;
        if (run_len > max_run) max_run = run_len;
      end else run_len = 0;
    end
  end

  task automatic send(input logic [47:0] w, input bit wide, input bit dbl);
    in_valid = 1; in_data = w; cfg_wide = wide; cfg_dbl = dbl;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(lnk_valid == 0 && lnk_data == 0 && underrun == 0 && in_ready == 1,
          "R1 reset", {lnk_valid, underrun, in_ready}, 3'b001);
    rst_n = 1;
    @(negedge clk);

    // R8: first beat two cycles after a transfer into an idle block
    send(48'h0000_8765_4321, 0, 0);
    check(lnk_valid == 0, "R8 no beat yet", lnk_valid, 0);
    idle(1);
    check(lnk_valid == 1 && lnk_data == 8'h1, "R8 first beat", lnk_data, 1);
    idle(12);

    // R5: each width/rate pair, singles with underrun at the end (R11)
    send(48'hBA98_7654_3210, 1, 0); idle(16);
    send(48'h0000_DEAD_BEEF, 0, 1); idle(8);
    send(48'h1122_3344_5566, 1, 1); idle(10);

    // R12: upper bits are garbage on a 32-bit word
    send(48'hFFFF_0F0F_A5A5, 0, 1); idle(8);

    // R9: back-to-back short words, no gap
    max_run = 0;
    for (int i = 0; i < 5; i++) send(48'(32'h0101_0101 * (i + 1)), 0, 1);
    idle(10);
    check(max_run == 20, "R9 gapless run", max_run, 20);

    // R6: settings changed while the word is shifting
    send(48'h9ABC_DEF0_1234, 1, 1);
    in_valid = 0; cfg_wide = 0; cfg_dbl = 0;
    idle(12);

    // Mixed stream with random gaps around the underrun boundary
    for (int i = 0; i < 60; i++) begin
      send({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, 1'($urandom), 1'($urandom));
      if ($urandom % 3 == 0) idle($urandom % 8);
    end
    idle(20);
    finish_run();
  end

endmodule